// File: doc/BRIEF.md
# Relative Branch Condition Unit

This block resolves one short relative branch per transfer. A request carries a one-byte branch opcode, an 8-bit two's-complement displacement, the address of the branch instruction and the four condition flags. The block maps the opcode to one condition. The conditions include signed comparisons, unsigned comparisons and tests of a single flag. It evaluates that condition against the flags and returns four things: whether control transfers, the address of the next instruction, whether the opcode belongs to the supported set, and how many program-fetch cycles the instruction takes.

Requests and results both move over valid/ready streams, with one register stage between them. A request is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. Its result is presented from the next cycle onward. The result stays presented, unchanged, until a rising edge at which `out_ready` is high. While a result is waiting and `out_ready` is low, `in_ready` stays low, so no request is lost or overwritten. When the consumer takes the waiting result, a new request can be accepted on that same edge. The block changes none of the flags: they go in as an input and never come back out.

Top module: `brc_unit`

## Requirements
- R1: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every result field holds its value into the next cycle. `in_ready` is high whenever no result is waiting or the waiting result is being taken.
- R2: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is low and `in_ready` is high.
- R3: When the branch is taken, `out_next_pc` equals the request address plus 2 plus the sign-extended displacement, wrapped modulo 2^16.
- R4: When the branch is not taken, `out_next_pc` equals the request address plus 2, wrapped modulo 2^16.
- R5: Opcode 0x20 is taken for every flag value. Opcode 0x21 is never taken.
- R6: Signed tests, with `in_flags` = {N,Z,V,C} on bits 3..0. Opcode 0x2F is taken when Z | (N ^ V) = 1. Opcode 0x2D is taken when N ^ V = 1.
- R7: Unsigned tests. Opcode 0x25 is taken when C = 1. Opcode 0x23 is taken when C | Z = 1.
- R8: Single-flag tests. 0x2B is taken on N = 1, 0x2A on N = 0, 0x26 on Z = 0, 0x28 on V = 0 and 0x29 on V = 1.
- R9: `out_cycles` is 3 for a taken branch and 1 for a branch that is not taken.
- R10: For an opcode outside the eleven listed in R5 to R8, `out_known` is low, `out_taken` is low, `out_cycles` is 1 and the next address is the request address plus 2. `out_known` is high for the eleven listed opcodes.
- R11: The result of a request accepted at a clock edge is presented with `out_valid` high in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_opcode | input | 8 | Branch opcode byte |
| in_offset | input | 8 | Two's-complement displacement |
| in_pc | input | 16 | Address of the branch instruction |
| in_flags | input | 4 | Flags {N,Z,V,C}, bit 3 down to bit 0 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_taken | output | 1 | Branch condition is met |
| out_known | output | 1 | Opcode is in the supported set |
| out_next_pc | output | 16 | Address of the next instruction |
| out_cycles | output | 2 | Program-fetch cycle count |

## Verification
The first result of a request is due one cycle after the edge that accepts it. Each directed task therefore drives the request on a falling edge and reads the result fields on the next falling edge. That sample point lies after the accepting rising edge and before the one that may consume the result. In the back-pressure scenario, a held result is re-sampled on several later falling edges while `out_ready` is low. The queued second request is then due one cycle after the edge on which `out_ready` returns high, and it is sampled at that point.

// File: rtl/brc_pkg.sv
package brc_pkg;

  localparam int FLAG_W = 4;
  localparam int FL_N   = 3;
  localparam int FL_Z   = 2;
  localparam int FL_V   = 1;
  localparam int FL_C   = 0;

  localparam logic [7:0] OPC_ALWAYS = 8'h20;
  localparam logic [7:0] OPC_NEVER  = 8'h21;
  localparam logic [7:0] OPC_ULS    = 8'h23;
  localparam logic [7:0] OPC_ULO    = 8'h25;
  localparam logic [7:0] OPC_NZ     = 8'h26;
  localparam logic [7:0] OPC_VCLR   = 8'h28;
  localparam logic [7:0] OPC_VSET   = 8'h29;
  localparam logic [7:0] OPC_POS    = 8'h2A;
  localparam logic [7:0] OPC_NEG    = 8'h2B;
  localparam logic [7:0] OPC_SLT    = 8'h2D;
  localparam logic [7:0] OPC_SLE    = 8'h2F;

  typedef enum logic [3:0] {
    COND_NONE,
    COND_ALWAYS,
    COND_NEVER,
    COND_SLE,
    COND_SLT,
    COND_ULO,
    COND_ULS,
    COND_NEG,
    COND_POS,
    COND_NZ,
    COND_VCLR,
    COND_VSET
  } cond_e;

endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] opcode,
  output cond_e           cond,
  output logic            known
);

  always_comb begin
    case (opcode)
      OP_W'(OPC_ALWAYS): cond = COND_ALWAYS;
      OP_W'(OPC_NEVER):  cond = COND_NEVER;
      OP_W'(OPC_SLE):    cond = COND_SLE;
      OP_W'(OPC_SLT):    cond = COND_SLT;
      OP_W'(OPC_ULO):    cond = COND_ULO;
      OP_W'(OPC_ULS):    cond = COND_ULS;
      OP_W'(OPC_NEG):    cond = COND_NEG;
      OP_W'(OPC_POS):    cond = COND_POS;
      OP_W'(OPC_NZ):     cond = COND_NZ;
      OP_W'(OPC_VCLR):   cond = COND_VCLR;
      OP_W'(OPC_VSET):   cond = COND_VSET;
      default:           cond = COND_NONE;
    endcase
  end

  assign known = (cond != COND_NONE);

endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  cond_e             cond,
  input  logic [FLAG_W-1:0] flags,
  output logic              hit
);

  logic f_n, f_z, f_v, f_c, lt_s;

  assign f_n  = flags[FL_N];
  assign f_z  = flags[FL_Z];
  assign f_v  = flags[FL_V];
  assign f_c  = flags[FL_C];
  assign lt_s = f_n ^ f_v;

  always_comb begin
    case (cond)
      COND_ALWAYS: hit = 1'b1;
      COND_NEVER:  hit = 1'b0;
      COND_SLE:    hit = f_z | lt_s;
      COND_SLT:    hit = lt_s;
      COND_ULO:    hit = f_c;
      COND_ULS:    hit = f_c | f_z;
      COND_NEG:    hit = f_n;
      COND_POS:    hit = ~f_n;
      COND_NZ:     hit = ~f_z;
      COND_VCLR:   hit = ~f_v;
      COND_VSET:   hit = f_v;
      default:     hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int PC_W  = 16,
  parameter int OFS_W = 8,
  parameter int ILEN  = 2
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFS_W-1:0] offset,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  jump_pc
);

  logic [PC_W-1:0] disp;

  generate
    if (PC_W > OFS_W) begin : g_extend
      assign disp = {{(PC_W-OFS_W){offset[OFS_W-1]}}, offset};
    end else begin : g_trunc
      assign disp = offset[PC_W-1:0];
    end
  endgenerate

  assign seq_pc  = pc + PC_W'(ILEN);
  assign jump_pc = seq_pc + disp;

endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int OFS_W     = 8,
  parameter int OP_W      = 8,
  parameter int TAKEN_CYC = 3,
  parameter int FALL_CYC  = 1,
  localparam int CYC_W    = $clog2(TAKEN_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_opcode,
  input  logic [OFS_W-1:0]  in_offset,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic              out_known,
  output logic [PC_W-1:0]   out_next_pc,
  output logic [CYC_W-1:0]  out_cycles
);

  cond_e           cond;
  logic            known, hit;
  logic [PC_W-1:0] seq_pc, jump_pc;
  logic            accept;

  brc_decode #(.OP_W(OP_W)) u_dec (
    .opcode (in_opcode),
    .cond   (cond),
    .known  (known)
  );

  brc_cond_eval u_eval (
    .cond  (cond),
    .flags (in_flags),
    .hit   (hit)
  );

  brc_target #(.PC_W(PC_W), .OFS_W(OFS_W), .ILEN(2)) u_tgt (
    .pc      (in_pc),
    .offset  (in_offset),
    .seq_pc  (seq_pc),
    .jump_pc (jump_pc)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_taken   <= 1'b0;
      out_known   <= 1'b0;
      out_next_pc <= '0;
      out_cycles  <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_taken   <= hit;
      out_known   <= known;
      out_next_pc <= hit ? jump_pc : seq_pc;
      out_cycles  <= hit ? CYC_W'(TAKEN_CYC) : CYC_W'(FALL_CYC);
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
  parameter int PC_W  = 16,
  parameter int OFS_W = 8,
  parameter int OP_W  = 8,
  parameter int CYC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OP_W-1:0]  in_opcode,
  input logic [OFS_W-1:0] in_offset,
  input logic [PC_W-1:0]  in_pc,
  input logic [3:0]       in_flags,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_taken,
  input logic             out_known,
  input logic [PC_W-1:0]  out_next_pc,
  input logic [CYC_W-1:0] out_cycles
);

  logic [PC_W-1:0]  cap_pc;
  logic [OFS_W-1:0] cap_off;
  logic [OP_W-1:0]  cap_op;
  logic [3:0]       cap_fl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_pc  <= '0;
      cap_off <= '0;
      cap_op  <= '0;
      cap_fl  <= '0;
    end else if (in_valid && in_ready) begin
      cap_pc  <= in_pc;
      cap_off <= in_offset;
      cap_op  <= in_opcode;
      cap_fl  <= in_flags;
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc) &&
      $stable(out_taken) && $stable(out_known) && $stable(out_cycles));

  assert_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_taken |->
      out_next_pc == cap_pc + PC_W'(2) + {{(PC_W-OFS_W){cap_off[OFS_W-1]}}, cap_off});

  assert_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_taken |-> out_next_pc == cap_pc + PC_W'(2));

  assert_always_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_op == OP_W'(8'h20) |-> out_taken);

  assert_never_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_op == OP_W'(8'h21) |-> !out_taken);

  assert_slt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_op == OP_W'(8'h2D) |-> out_taken == (cap_fl[3] ^ cap_fl[1]));

  assert_cyc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_cycles == (out_taken ? CYC_W'(3) : CYC_W'(1)));

  assert_unknown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_known |-> !out_taken);

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

endmodule

bind brc_unit brc_unit_chk #(
  .PC_W(PC_W), .OFS_W(OFS_W), .OP_W(OP_W), .CYC_W(CYC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_opcode(in_opcode), .in_offset(in_offset), .in_pc(in_pc),
  .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
  .out_taken(out_taken), .out_known(out_known), .out_next_pc(out_next_pc),
  .out_cycles(out_cycles)
);

// File: tb/brc_unit_test.sv
module brc_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic [7:0]  in_offset = '0;
  logic [15:0] in_pc = '0;
  logic [3:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_taken;
  logic        out_known;
  logic [15:0] out_next_pc;
  logic [1:0]  out_cycles;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brc_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_offset(in_offset), .in_pc(in_pc),
    .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_taken(out_taken), .out_known(out_known), .out_next_pc(out_next_pc),
    .out_cycles(out_cycles)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Sends one request, checks its result one cycle after acceptance.
  task automatic xfer(input logic [7:0] op, input logic [7:0] off,
                      input logic [15:0] pc, input logic [3:0] fl,
                      input bit exp_taken, input bit exp_known, input string req);
    logic [15:0] exp_pc;
    exp_pc = exp_taken ? pc + 16'd2 + {{8{off[7]}}, off} : pc + 16'd2;
    @(negedge clk);
    in_opcode = op; in_offset = off; in_pc = pc; in_flags = fl; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 out_valid", out_valid, 1);
    chk(req, out_taken, exp_taken);
    chk("R10 out_known", out_known, exp_known);
    chk(exp_taken ? "R3 next_pc" : "R4 next_pc", out_next_pc, exp_pc);
    chk("R9 cycles", out_cycles, exp_taken ? 2'd3 : 2'd1);
  endtask

  task automatic t_reset();
    #(CLK_PERIOD/4);
    chk("R2 out_valid in reset", out_valid, 0);
    chk("R2 in_ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2 out_valid after reset", out_valid, 0);
    chk("R2 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_fixed();
    for (int f = 0; f < 16; f++) begin
      xfer(8'h20, 8'h10, 16'h1000, 4'(f), 1'b1, 1'b1, "R5 always");
      xfer(8'h21, 8'h10, 16'h1000, 4'(f), 1'b0, 1'b1, "R5 never");
    end
    xfer(8'h20, 8'h7F, 16'hFFF0, 4'h0, 1'b1, 1'b1, "R3 wrap forward");
    chk("R3 wrap value", out_next_pc, 16'h0071);
    xfer(8'h20, 8'h80, 16'h0005, 4'h0, 1'b1, 1'b1, "R3 backward");
    chk("R3 backward value", out_next_pc, 16'hFF87);
  endtask

  task automatic t_signed();
    for (int f = 0; f < 16; f++) begin
      bit n, z, v;
      n = f[3]; z = f[2]; v = f[1];
      xfer(8'h2F, 8'hF0, 16'h4000, 4'(f), z | (n ^ v), 1'b1, "R6 signed le");
      xfer(8'h2D, 8'h22, 16'h4000, 4'(f), n ^ v, 1'b1, "R6 signed lt");
    end
  endtask

  task automatic t_unsigned();
    for (int f = 0; f < 16; f++) begin
      bit z, c;
      z = f[2]; c = f[0];
      xfer(8'h25, 8'h05, 16'h2222, 4'(f), c, 1'b1, "R7 lower");
      xfer(8'h23, 8'hFE, 16'h2222, 4'(f), c | z, 1'b1, "R7 lower or same");
    end
  endtask

  task automatic t_single();
    for (int f = 0; f < 16; f++) begin
      xfer(8'h2B, 8'h40, 16'h8000, 4'(f), f[3],  1'b1, "R8 minus");
      xfer(8'h2A, 8'h40, 16'h8000, 4'(f), !f[3], 1'b1, "R8 plus");
      xfer(8'h26, 8'h40, 16'h8000, 4'(f), !f[2], 1'b1, "R8 not zero");
      xfer(8'h28, 8'h40, 16'h8000, 4'(f), !f[1], 1'b1, "R8 v clear");
      xfer(8'h29, 8'h40, 16'h8000, 4'(f), f[1],  1'b1, "R8 v set");
    end
  endtask

  task automatic t_unknown();
    xfer(8'h27, 8'h10, 16'h3000, 4'hF, 1'b0, 1'b0, "R10 taken 0x27");
    xfer(8'h22, 8'h10, 16'h3000, 4'h0, 1'b0, 1'b0, "R10 taken 0x22");
    xfer(8'h00, 8'h10, 16'h3000, 4'h4, 1'b0, 1'b0, "R10 taken 0x00");
    xfer(8'hA0, 8'h80, 16'hFFFF, 4'hF, 1'b0, 1'b0, "R10 taken 0xA0");
    chk("R4 sequential wrap", out_next_pc, 16'h0001);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_opcode = 8'h20; in_offset = 8'h08; in_pc = 16'h0100; in_flags = 4'h0;
    in_valid = 1'b1;
    @(negedge clk);
    in_opcode = 8'h21; in_offset = 8'h00; in_pc = 16'h0200;
    chk("R11 first result", out_valid, 1);
    chk("R1 in_ready low while stalled", in_ready, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 held valid", out_valid, 1);
      chk("R1 held next_pc", out_next_pc, 16'h010A);
      chk("R1 held taken", out_taken, 1);
      chk("R1 held cycles", out_cycles, 2'd3);
      chk("R1 in_ready stays low", in_ready, 0);
    end
    out_ready = 1'b1;
    #1;
    chk("R1 in_ready with consumer ready", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 queued result valid", out_valid, 1);
    chk("R1 queued next_pc", out_next_pc, 16'h0202);
    chk("R1 queued taken", out_taken, 0);
    @(negedge clk);
    chk("R1 drained", out_valid, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fixed();
    t_signed();
    t_unsigned();
    t_single();
    t_unknown();
    t_backpressure();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule